// File: doc/BRIEF.md
# Slot Hot-Plug Event Controller

This block collects slot insertion and removal events and reports them to system software through a small general-purpose event (GPE) register window and a pair of slot bitmaps. Each event carries a slot number. The block sets a shared hot-plug status flag, records the slot in an "inserted" or a "removed" bitmap, and raises an interrupt condition when that flag is enabled. Software reads the bitmaps to find out which slot changed. It acknowledges the event by writing a one to the status flag.

The GPE window is byte-addressed and holds two 16-bit registers. A 32-bit register port reaches the two bitmaps and an eject register. A write to the eject register names slots as a bit mask. The block converts the mask into a single slot index and issues a one-cycle strobe that carries it. Devices that are already present at power-on are flagged as cold-plug and are ignored.

Top module: `hp_event_ctrl`

## Requirements
- R1: After reset, GPE status, GPE enable and both slot bitmaps are zero, `gpe_irq` is 0 and `ej_strobe` is 0.
- R2: A GPE byte write at offset 0 (status low byte, `gpe_addr[0]`=0) or offset 1 (status high byte) clears each status bit written as 1 in that byte only. Bits written as 0 and the other byte keep their value.
- R3: A GPE byte write at offset 2 (enable low byte) or offset 3 (enable high byte) replaces that byte of the enable register and leaves the other byte unchanged.
- R4: `gpe_rdata` returns the status low byte, status high byte, enable low byte or enable high byte for `gpe_addr` 0, 1, 2 or 3, combinationally.
- R5: `gpe_irq` is 1 exactly while status bit 1 and enable bit 1 are both set.
- R6: An accepted event clears both bitmaps and then sets bit[`hp_slot`] in the inserted bitmap (`hp_remove`=0) or in the removed bitmap (`hp_remove`=1). It also sets status bit 1. All of this is visible after the event's clock edge.
- R7: An event with `hp_cold`=1 changes no bitmap and no status bit.
- R8: On the register port, `reg_addr`=0 reaches the inserted bitmap and `reg_addr`=1 reaches the removed bitmap; both can be read and written. `reg_addr`=2 (eject) and 3 read as zero, and a write to index 3 changes nothing.
- R9: A write of a nonzero mask at `reg_addr`=2 gives `ej_strobe`=1 for exactly the next cycle. In that cycle `ej_slot` holds the index of the lowest set bit of the mask.
- R10: A write of zero at `reg_addr`=2 gives no strobe.
- R11: When an accepted event and a software bitmap write or status clear fall in the same cycle, the event's result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpe_wr | input | 1 | GPE byte write strobe |
| gpe_addr | input | 2 | GPE byte offset |
| gpe_wdata | input | 8 | GPE write byte |
| gpe_rdata | output | 8 | GPE read byte |
| reg_wr | input | 1 | Register-port write strobe |
| reg_addr | input | 2 | Register-port word index |
| reg_wdata | input | 32 | Register-port write data |
| reg_rdata | output | 32 | Register-port read data |
| hp_valid | input | 1 | Slot event valid |
| hp_remove | input | 1 | 1 = removal, 0 = insertion |
| hp_cold | input | 1 | Event belongs to a device present at power-on |
| hp_slot | input | 5 | Slot number of the event |
| gpe_irq | output | 1 | Hot-plug interrupt condition |
| ej_strobe | output | 1 | One-cycle eject request |
| ej_slot | output | 5 | Slot to eject, valid with the strobe |

## Verification
A wrong bitmap or status bit is visible on `reg_rdata` or `gpe_rdata` in the cycle right after the clock edge that updated it, because the reads are combinational. Errors in the event path also show on `gpe_irq` one edge after the event. An error in the eject decoder shows as a missing or mistimed strobe, or a wrong `ej_slot`, in the cycle that follows the write. The directed scenarios check each of these windows directly. They also cover same-cycle collisions between an event and software access.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;
  localparam int WORD_W = 32;
  localparam int GPE_W  = 16;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    WIN_UP    = 2'd0,
    WIN_DOWN  = 2'd1,
    WIN_EJECT = 2'd2,
    WIN_NONE  = 2'd3
  } win_t;

  // Index of the lowest set bit; zero when the mask is empty.
  function automatic logic [4:0] first_one(input logic [WORD_W-1:0] m);
    logic [4:0] r;
    r = 5'd0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (m[i]) r = i[4:0];
    end
    return r;
  endfunction

  // Clear the bits written as one in the selected byte lane.
  function automatic logic [GPE_W-1:0] lane_clear(input logic [GPE_W-1:0] cur,
                                                  input logic hi,
                                                  input logic [LANE_W-1:0] b);
    if (hi) return {cur[15:8] & ~b, cur[7:0]};
    return {cur[15:8], cur[7:0] & ~b};
  endfunction

  // Replace the selected byte lane.
  function automatic logic [GPE_W-1:0] lane_put(input logic [GPE_W-1:0] cur,
                                                input logic hi,
                                                input logic [LANE_W-1:0] b);
    if (hi) return {b, cur[7:0]};
    return {cur[15:8], b};
  endfunction

  function automatic logic [LANE_W-1:0] lane_get(input logic [GPE_W-1:0] cur,
                                                 input logic hi);
    return hi ? cur[15:8] : cur[7:0];
  endfunction
endpackage

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs
  import hp_evt_pkg::*;
#(
  parameter int HP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [LANE_W-1:0] wdata,
  input  logic              hp_set,
  output logic [GPE_W-1:0]  sts,
  output logic [GPE_W-1:0]  en,
  output logic [LANE_W-1:0] rdata
);
  logic [GPE_W-1:0] sts_n, en_n;

  always_comb begin
    sts_n = sts;
    en_n  = en;
    if (wr && !addr[1]) sts_n = lane_clear(sts, addr[0], wdata);
    if (wr &&  addr[1]) en_n  = lane_put(en, addr[0], wdata);
    if (hp_set) sts_n[HP_BIT] = 1'b1;   // event wins over a same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
    end else begin
      sts <= sts_n;
      en  <= en_n;
    end
  end

  assign rdata = addr[1] ? lane_get(en, addr[0]) : lane_get(sts, addr[0]);
endmodule

// File: rtl/hp_slot_maps.sv
module hp_slot_maps
  import hp_evt_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  win_t                 sel,
  input  logic [NUM_SLOTS-1:0] wdata,
  input  logic                 hp_fire,
  input  logic                 hp_remove,
  input  logic [SLOT_W-1:0]    hp_slot,
  output logic [NUM_SLOTS-1:0] up_map,
  output logic [NUM_SLOTS-1:0] down_map
);
  logic [NUM_SLOTS-1:0] slot_bit;
  assign slot_bit = {{(NUM_SLOTS-1){1'b0}}, 1'b1} << hp_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_map   <= '0;
      down_map <= '0;
    end else if (hp_fire) begin
      up_map   <= hp_remove ? '0 : slot_bit;
      down_map <= hp_remove ? slot_bit : '0;
    end else if (wr) begin
      if (sel == WIN_UP)   up_map   <= wdata;
      if (sel == WIN_DOWN) down_map <= wdata;
    end
  end
endmodule

// File: rtl/hp_eject_decode.sv
module hp_eject_decode
  import hp_evt_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] mask,
  output logic              strobe,
  output logic [SLOT_W-1:0] slot
);
  logic       nonzero;
  logic [4:0] idx;
  assign nonzero = |mask;
  assign idx     = first_one(mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe <= 1'b0;
      slot   <= '0;
    end else begin
      strobe <= wr_hit && nonzero;
      if (wr_hit && nonzero) slot <= SLOT_W'(idx);
    end
  end
endmodule

// File: rtl/hp_event_ctrl.sv
module hp_event_ctrl
  import hp_evt_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int HP_BIT    = 1,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gpe_wr,
  input  logic [1:0]        gpe_addr,
  input  logic [7:0]        gpe_wdata,
  output logic [7:0]        gpe_rdata,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              hp_valid,
  input  logic              hp_remove,
  input  logic              hp_cold,
  input  logic [SLOT_W-1:0] hp_slot,
  output logic              gpe_irq,
  output logic              ej_strobe,
  output logic [SLOT_W-1:0] ej_slot
);
  // Named internal events, visible to the checker.
  logic                 hp_fire, map_wr_hit, ej_wr_hit, sts_hp, en_hp;
  logic [GPE_W-1:0]     sts, en;
  logic [NUM_SLOTS-1:0] up_map, down_map;
  win_t                 win;

  assign win        = win_t'(reg_addr);
  assign hp_fire    = hp_valid && !hp_cold;
  assign map_wr_hit = reg_wr && (win == WIN_UP || win == WIN_DOWN);
  assign ej_wr_hit  = reg_wr && (win == WIN_EJECT);

  hp_gpe_regs #(.HP_BIT(HP_BIT)) u_gpe (
    .clk(clk), .rst_n(rst_n), .wr(gpe_wr), .addr(gpe_addr), .wdata(gpe_wdata),
    .hp_set(hp_fire), .sts(sts), .en(en), .rdata(gpe_rdata)
  );

  hp_slot_maps #(.NUM_SLOTS(NUM_SLOTS)) u_maps (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(win),
    .wdata(reg_wdata[NUM_SLOTS-1:0]), .hp_fire(hp_fire),
    .hp_remove(hp_remove), .hp_slot(hp_slot),
    .up_map(up_map), .down_map(down_map)
  );

  hp_eject_decode #(.SLOT_W(SLOT_W)) u_eject (
    .clk(clk), .rst_n(rst_n), .wr_hit(ej_wr_hit), .mask(reg_wdata),
    .strobe(ej_strobe), .slot(ej_slot)
  );

  assign sts_hp  = sts[HP_BIT];
  assign en_hp   = en[HP_BIT];
  assign gpe_irq = sts_hp && en_hp;

  always_comb begin
    case (win)
      WIN_UP:   reg_rdata = WORD_W'(up_map);
      WIN_DOWN: reg_rdata = WORD_W'(down_map);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hp_event_ctrl_checker.sv
module hp_event_ctrl_checker #(
  parameter int NS = 32,
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hp_fire,
  input logic          hp_valid,
  input logic          hp_cold,
  input logic          hp_remove,
  input logic [SW-1:0] hp_slot,
  input logic          gpe_wr,
  input logic          map_wr_hit,
  input logic          ej_wr_hit,
  input logic [31:0]   reg_wdata,
  input logic [NS-1:0] up_map,
  input logic [NS-1:0] down_map,
  input logic          sts_hp,
  input logic          en_hp,
  input logic          gpe_irq,
  input logic          ej_strobe,
  input logic [SW-1:0] ej_slot
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (up_map == '0 && down_map == '0 && !sts_hp
                                     && !en_hp && !ej_strobe);
    end
  end

  assert_event_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hp_fire |=> sts_hp);

  assert_insert_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_fire && !hp_remove) |=>
      (up_map == ({{(NS-1){1'b0}}, 1'b1} << $past(hp_slot)) && down_map == '0));

  assert_remove_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_fire && hp_remove) |=>
      (down_map == ({{(NS-1){1'b0}}, 1'b1} << $past(hp_slot)) && up_map == '0));

  assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_fire && map_wr_hit) |=> ($countones({up_map, down_map}) == 1));

  assert_cold_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_valid && hp_cold && !map_wr_hit) |=> ($stable(up_map) && $stable(down_map)));

  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_fire && en_hp && !gpe_wr) |=> gpe_irq);

  assert_eject_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ej_strobe |-> ($past(ej_wr_hit)
                   && ((($past(reg_wdata) >> ej_slot) & 32'd1) == 32'd1)
                   && (($past(reg_wdata) & ((32'd1 << ej_slot) - 32'd1)) == 32'd0)));

  assert_eject_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_wr_hit && reg_wdata == 32'd0) |=> !ej_strobe);
endmodule

bind hp_event_ctrl hp_event_ctrl_checker #(.NS(NUM_SLOTS), .SW(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hp_fire(hp_fire), .hp_valid(hp_valid),
  .hp_cold(hp_cold), .hp_remove(hp_remove), .hp_slot(hp_slot),
  .gpe_wr(gpe_wr), .map_wr_hit(map_wr_hit), .ej_wr_hit(ej_wr_hit),
  .reg_wdata(reg_wdata), .up_map(up_map), .down_map(down_map),
  .sts_hp(sts_hp), .en_hp(en_hp), .gpe_irq(gpe_irq),
  .ej_strobe(ej_strobe), .ej_slot(ej_slot)
);

// File: tb/hp_event_ctrl_test.sv
`timescale 1ns/1ps
module hp_event_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gpe_wr = 1'b0;
  logic [1:0]  gpe_addr = 2'd0;
  logic [7:0]  gpe_wdata = 8'd0;
  logic [7:0]  gpe_rdata;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        hp_valid = 1'b0;
  logic        hp_remove = 1'b0;
  logic        hp_cold = 1'b0;
  logic [4:0]  hp_slot = 5'd0;
  logic        gpe_irq;
  logic        ej_strobe;
  logic [4:0]  ej_slot;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hp_event_ctrl uut (
    .clk(clk), .rst_n(rst_n), .gpe_wr(gpe_wr), .gpe_addr(gpe_addr),
    .gpe_wdata(gpe_wdata), .gpe_rdata(gpe_rdata), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hp_valid(hp_valid), .hp_remove(hp_remove), .hp_cold(hp_cold),
    .hp_slot(hp_slot), .gpe_irq(gpe_irq), .ej_strobe(ej_strobe), .ej_slot(ej_slot)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", what, act, exp);
    end
  endtask

  function automatic logic [4:0] lowest_bit(input logic [31:0] m);
    int k = 0;
    while (k < 31 && !m[k]) k++;
    return 5'(k);
  endfunction

  task automatic gpe_put(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); gpe_addr = a; gpe_wdata = d; gpe_wr = 1'b1;
    @(negedge clk); gpe_wr = 1'b0;
  endtask

  task automatic gpe_get(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); gpe_addr = a; #1 v = gpe_rdata;
  endtask

  task automatic reg_put(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_get(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic hp_event(input logic [4:0] s, input logic rem, input logic cold);
    @(negedge clk); hp_slot = s; hp_remove = rem; hp_cold = cold; hp_valid = 1'b1;
    @(negedge clk); hp_valid = 1'b0; hp_cold = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] b; logic [31:0] w;
    for (int a = 0; a < 4; a++) begin gpe_get(2'(a), b); check(32'(b), 0, "R1 gpe byte"); end
    reg_get(2'd0, w); check(w, 0, "R1 up map");
    reg_get(2'd1, w); check(w, 0, "R1 down map");
    check(32'(gpe_irq), 0, "R1 irq");
    check(32'(ej_strobe), 0, "R1 strobe");
  endtask

  task automatic t_enable;
    logic [7:0] b;
    gpe_put(2'd2, 8'h02); gpe_put(2'd3, 8'hA5);
    gpe_get(2'd2, b); check(32'(b), 32'h02, "R3/R4 enable low");
    gpe_get(2'd3, b); check(32'(b), 32'hA5, "R3/R4 enable high");
    gpe_put(2'd3, 8'h3C);
    gpe_get(2'd2, b); check(32'(b), 32'h02, "R3 low lane kept");
    gpe_get(2'd3, b); check(32'(b), 32'h3C, "R3 high lane replaced");
  endtask

  task automatic t_event;
    logic [7:0] b; logic [31:0] w;
    hp_event(5'd5, 1'b0, 1'b0);
    reg_get(2'd0, w); check(w, 32'h20, "R6 insert up map");
    reg_get(2'd1, w); check(w, 0, "R6 insert down map");
    gpe_get(2'd0, b); check(32'(b), 32'h02, "R6 status bit1");
    check(32'(gpe_irq), 1, "R5 irq raised");
    hp_event(5'd31, 1'b1, 1'b0);
    reg_get(2'd0, w); check(w, 0, "R6 remove wipes up map");
    reg_get(2'd1, w); check(w, 32'h8000_0000, "R6 remove down map");
  endtask

  task automatic t_status_clear;
    logic [7:0] b;
    gpe_put(2'd1, 8'hFF);
    gpe_get(2'd0, b); check(32'(b), 32'h02, "R2 other lane untouched");
    check(32'(gpe_irq), 1, "R5 irq held");
    gpe_put(2'd0, 8'h01);
    gpe_get(2'd0, b); check(32'(b), 32'h02, "R2 zero bits kept");
    gpe_put(2'd0, 8'h02);
    gpe_get(2'd0, b); check(32'(b), 0, "R2 bit cleared");
    check(32'(gpe_irq), 0, "R5 irq dropped");
  endtask

  task automatic t_mask;
    logic [7:0] b;
    gpe_put(2'd2, 8'h00);
    hp_event(5'd2, 1'b0, 1'b0);
    gpe_get(2'd0, b); check(32'(b), 32'h02, "R6 status with enable off");
    check(32'(gpe_irq), 0, "R5 irq masked");
    gpe_put(2'd2, 8'h02);
    #1 check(32'(gpe_irq), 1, "R5 irq after enable");
    gpe_put(2'd0, 8'h02);
  endtask

  task automatic t_cold;
    logic [7:0] b; logic [31:0] w;
    reg_put(2'd0, 32'h0000_0011);
    hp_event(5'd3, 1'b1, 1'b1);
    reg_get(2'd0, w); check(w, 32'h11, "R7 up map unchanged");
    reg_get(2'd1, w); check(w, 0, "R7 down map unchanged");
    gpe_get(2'd0, b); check(32'(b), 0, "R7 status unchanged");
  endtask

  task automatic t_maps;
    logic [31:0] w;
    reg_put(2'd0, 32'hDEAD_BEEF); reg_put(2'd1, 32'h1234_5678);
    reg_get(2'd0, w); check(w, 32'hDEAD_BEEF, "R8 up readback");
    reg_get(2'd1, w); check(w, 32'h1234_5678, "R8 down readback");
    reg_put(2'd3, 32'hFFFF_FFFF);
    reg_get(2'd3, w); check(w, 0, "R8 index3 reads zero");
    reg_get(2'd2, w); check(w, 0, "R8 eject reads zero");
    reg_get(2'd0, w); check(w, 32'hDEAD_BEEF, "R8 index3 write ignored");
  endtask

  task automatic t_priority;
    logic [7:0] b; logic [31:0] w;
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 32'hFFFF_FFFF; reg_wr = 1'b1;
    gpe_addr = 2'd0; gpe_wdata = 8'h02; gpe_wr = 1'b1;
    hp_slot = 5'd9; hp_remove = 1'b0; hp_cold = 1'b0; hp_valid = 1'b1;
    @(negedge clk); reg_wr = 1'b0; gpe_wr = 1'b0; hp_valid = 1'b0;
    reg_get(2'd0, w); check(w, 32'h200, "R11 event beats map write");
    reg_get(2'd1, w); check(w, 0, "R11 down cleared");
    gpe_get(2'd0, b); check(32'(b), 32'h02, "R11 event beats status clear");
    gpe_put(2'd0, 8'h02);
  endtask

  task automatic t_eject(input logic [31:0] m);
    reg_put(2'd2, m);
    if (m != 0) begin
      check(32'(ej_strobe), 1, "R9 strobe");
      check(32'(ej_slot), 32'(lowest_bit(m)), "R9 slot index");
    end else begin
      check(32'(ej_strobe), 0, "R10 no strobe on zero");
    end
    @(negedge clk); check(32'(ej_strobe), 0, "R9 strobe one cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_event();
    t_status_clear();
    t_mask();
    t_cold();
    t_maps();
    t_priority();
    t_eject(32'h0000_0050);
    t_eject(32'h8000_0000);
    t_eject(32'h0000_0001);
    t_eject(32'h0F00_0C00);
    t_eject(32'h0000_0000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule